// File: doc/BRIEF.md
# Programming-Path CRC-16 Accumulator

This block keeps a 16-bit running checksum over the bytes written to flash during a byte-serial in-system programming session. The host then reads one 16-bit value through a command read and compares it with its own sum, so it does not have to read back every programmed byte. Only bytes the slave acknowledged as write data are folded in. Address bytes and the data byte of an erase or blank operation are passed by unchanged.

The register is seeded with all ones by reset or by a one-cycle clear pulse. Each qualified byte is folded in most significant bit first. Per bit, the feedback is the top register bit XOR the data bit. The register shifts left by one and takes the feedback into bit 0. The feedback is also XORed into the bits that leave positions 14 and 1, which become bits 15 and 2. This is the 8005h polynomial. The eight bit steps are unrolled into combinational logic, so a byte is absorbed in one clock cycle. The output comes straight from the register and changes only on the clock edge after a qualified byte or a clear.

Top module: `pgm_crc_accum`

## Requirements
- R1: While `rst_n` is low, and after its release with no other activity, `crc_value` is FFFFh.
- R2: A `crc_clr` pulse makes `crc_value` FFFFh on the following clock edge, whatever its previous value.
- R3: A byte is qualified when `byte_vld`=1, `byte_ack`=1, `byte_skip`=0 and `crc_clr`=0 in the same cycle. For a qualified byte, `crc_value` after the next clock edge equals the old value with all eight bits of `byte_data` folded in by the rule of R6.
- R4: A byte presented with `byte_ack`=0 leaves `crc_value` unchanged.
- R5: A byte presented with `byte_skip`=1 (an address or erase/blank byte) leaves `crc_value` unchanged, even when `byte_ack`=1.
- R6: Bits are folded MSB first (bit 7 down to bit 0). For each bit b: fb = crc[15]^b, and the next value is {crc[14]^fb, crc[13:2], crc[1]^fb, crc[0], fb}. From FFFFh, the bytes F6h, 28h and C3h give FF36h, 34F2h and 7031h in turn.
- R7: When `crc_clr` and a qualified byte arrive in the same cycle, the result is FFFFh and the byte is discarded.
- R8: With `byte_vld`=0 and `crc_clr`=0, `crc_value` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; seeds the register |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Value of the received byte |
| byte_ack | input | 1 | The slave acknowledged the byte as write data |
| byte_skip | input | 1 | The byte is an address or erase/blank byte and must not be summed |
| crc_clr | input | 1 | Clear command pulse; loads all ones |
| crc_value | output | 16 | Registered running CRC |

## Verification
The bench runs the three-byte worked example against fixed constants. A design that folds LSB first or uses the wrong taps fails at the first byte. It presents unacknowledged and skipped bytes, including skipped bytes that are acknowledged, between real ones. A design that ignores one of the qualifiers would corrupt every later value. It drives a clear together with a qualified byte, where a design that gives priority to the byte would leave a non-seed value. It also runs a long mixed stream against a bit-serial model, which exposes a wrong polynomial or any single-cycle slip in the update.

// File: rtl/pgm_crc_pkg.sv
package pgm_crc_pkg;
   localparam int unsigned DEF_CRC_W  = 16;
   localparam int unsigned DEF_DATA_W = 8;
   localparam logic [DEF_CRC_W-1:0] DEF_POLY = 16'h8005;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_FOLD = 2'd1,
      ACT_SEED = 2'd2
   } crc_act_e;
endpackage

// File: rtl/pgm_crc_qualify.sv
module pgm_crc_qualify
   import pgm_crc_pkg::*;
(
   input  logic     byte_vld,
   input  logic     byte_ack,
   input  logic     byte_skip,
   input  logic     crc_clr,
   output crc_act_e act
);
   logic counted;

   assign counted = byte_vld & byte_ack & ~byte_skip;

   always_comb begin
      if (crc_clr)      act = ACT_SEED;
      else if (counted) act = ACT_FOLD;
      else              act = ACT_HOLD;
   end
endmodule

// File: rtl/pgm_crc_fold.sv
module pgm_crc_fold #(
   parameter int unsigned CRC_W  = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY = 16'h8005,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   logic [CRC_W-1:0] chain [DATA_W+1];
   logic [DATA_W-1:0] order;

   initial begin
      if (CRC_W < 2)   $error("pgm_crc_fold: CRC_W must be at least 2");
      if (DATA_W < 1)  $error("pgm_crc_fold: DATA_W must be at least 1");
      if (!POLY[0])    $error("pgm_crc_fold: POLY bit 0 must be set");
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign order = data_in;
      end else begin : g_lsb
         for (genvar k = 0; k < DATA_W; k++) begin : g_rev
            assign order[k] = data_in[DATA_W-1-k];
         end
      end
   endgenerate

   assign chain[0] = crc_in;

   generate
      for (genvar s = 0; s < DATA_W; s++) begin : g_step
         logic fb;
         assign fb = chain[s][CRC_W-1] ^ order[DATA_W-1-s];
         assign chain[s+1] = {chain[s][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   endgenerate

   assign crc_out = chain[DATA_W];
endmodule

// File: rtl/pgm_crc_reg.sv
module pgm_crc_reg
   import pgm_crc_pkg::*;
#(
   parameter int unsigned CRC_W = 16,
   parameter logic [CRC_W-1:0] SEED = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  crc_act_e         act,
   input  logic [CRC_W-1:0] folded,
   output logic [CRC_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= SEED;
      end else begin
         unique case (act)
            ACT_SEED: q <= SEED;
            ACT_FOLD: q <= folded;
            default:  q <= q;
         endcase
      end
   end
endmodule

// File: rtl/pgm_crc_accum.sv
module pgm_crc_accum
   import pgm_crc_pkg::*;
#(
   parameter int unsigned CRC_W  = DEF_CRC_W,
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter logic [CRC_W-1:0] POLY = DEF_POLY,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              byte_ack,
   input  logic              byte_skip,
   input  logic              crc_clr,
   output logic [CRC_W-1:0]  crc_value
);
   localparam logic [CRC_W-1:0] SEED = {CRC_W{1'b1}};

   crc_act_e         act;
   logic [CRC_W-1:0] folded;

   pgm_crc_qualify u_qual (
      .byte_vld (byte_vld),
      .byte_ack (byte_ack),
      .byte_skip(byte_skip),
      .crc_clr  (crc_clr),
      .act      (act)
   );

   pgm_crc_fold #(
      .CRC_W    (CRC_W),
      .DATA_W   (DATA_W),
      .POLY     (POLY),
      .MSB_FIRST(MSB_FIRST)
   ) u_fold (
      .crc_in (crc_value),
      .data_in(byte_data),
      .crc_out(folded)
   );

   pgm_crc_reg #(
      .CRC_W(CRC_W),
      .SEED (SEED)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .folded(folded),
      .q     (crc_value)
   );
endmodule

// File: rtl/pgm_crc_accum_chk.sv
module pgm_crc_accum_chk #(
   parameter int unsigned CRC_W  = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              byte_vld,
   input logic [DATA_W-1:0] byte_data,
   input logic              byte_ack,
   input logic              byte_skip,
   input logic              crc_clr,
   input logic [CRC_W-1:0]  crc_value
);
   localparam logic [CRC_W-1:0] ONES = {CRC_W{1'b1}};

   function automatic logic [CRC_W-1:0] serial_fold(input logic [CRC_W-1:0] c,
                                                    input logic [DATA_W-1:0] d);
      logic [CRC_W-1:0] r;
      logic t;
      r = c;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         t = r[CRC_W-1] ^ d[i];
         r = {r[CRC_W-2:0], t};
         r[2]       = r[2] ^ t;
         r[CRC_W-1] = r[CRC_W-1] ^ t;
      end
      return r;
   endfunction

   AST_RESET_SEED: assert property (@(posedge clk) !rst_n |=> crc_value == ONES); // R1
   AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      crc_clr |=> crc_value == ONES); // R2
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_clr && byte_vld && byte_ack && !byte_skip) |=> crc_value == ONES); // R7
   AST_FOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_ack && !byte_skip && !crc_clr) |=>
      crc_value == serial_fold($past(crc_value), $past(byte_data))); // R3
   AST_NOACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_ack && !crc_clr) |=> $stable(crc_value)); // R4
   AST_SKIP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_skip && !crc_clr) |=> $stable(crc_value)); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld && !crc_clr) |=> $stable(crc_value)); // R8
endmodule

bind pgm_crc_accum pgm_crc_accum_chk #(
   .CRC_W (CRC_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .byte_vld (byte_vld),
   .byte_data(byte_data),
   .byte_ack (byte_ack),
   .byte_skip(byte_skip),
   .crc_clr  (crc_clr),
   .crc_value(crc_value)
);

// File: tb/pgm_crc_accum_test.sv
`timescale 1ns/1ps
module pgm_crc_accum_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        byte_ack = 1'b0;
   logic        byte_skip = 1'b0;
   logic        crc_clr = 1'b0;
   logic [15:0] crc_value;

   int compared = 0;
   int mismatched = 0;
   logic [15:0] model = 16'hFFFF;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #4 clk = ~clk;

   pgm_crc_accum uut (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
      .byte_ack(byte_ack), .byte_skip(byte_skip), .crc_clr(crc_clr),
      .crc_value(crc_value)
   );

   function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      logic fb;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         fb = r[15] ^ d[i];
         r  = {r[14] ^ fb, r[13:2], r[1] ^ fb, r[0], fb};
      end
      return r;
   endfunction

   // Driver: applies one cycle of stimulus at the falling edge, queues the expectation.
   task automatic drive(input logic v, input logic [7:0] d, input logic a,
                        input logic s, input logic c, input string tag,
                        input bit use_const = 0, input logic [15:0] const_val = '0);
      @(negedge clk);
      byte_vld = v; byte_data = d; byte_ack = a; byte_skip = s; crc_clr = c;
      if (c)                 model = 16'hFFFF;
      else if (v && a && !s) model = ref_step(model, d);
      exp_q.push_back(use_const ? const_val : model);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares after each rising edge, well clear of the edge.
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         compared++;
         if (crc_value !== e) begin
            mismatched++;
            $display("FAIL %s: crc_value=%h expected=%h", t, crc_value, e);
         end
      end
   end

   initial begin
      #1600000;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: value held in reset
      compared++;
      if (crc_value !== 16'hFFFF) begin
         mismatched++;
         $display("FAIL R1: crc_value=%h expected=ffff", crc_value);
      end
      rst_n = 1'b1;
      drive(0, 8'h00, 0, 0, 0, "R1");
      // R6 worked example with fixed constants
      drive(1, 8'hF6, 1, 0, 0, "R6", 1, 16'hFF36);
      drive(1, 8'h28, 1, 0, 0, "R6", 1, 16'h34F2);
      drive(1, 8'hC3, 1, 0, 0, "R6", 1, 16'h7031);
      drive(0, 8'hAA, 1, 0, 0, "R8");
      drive(0, 8'h55, 0, 0, 0, "R8");
      drive(1, 8'h5A, 0, 0, 0, "R4");
      drive(1, 8'h77, 0, 1, 0, "R4");
      drive(1, 8'h12, 1, 1, 0, "R5");
      drive(1, 8'h00, 1, 0, 0, "R3");
      drive(1, 8'hFF, 1, 0, 0, "R3");
      drive(1, 8'h9C, 1, 1, 0, "R5");
      drive(0, 8'h00, 0, 0, 1, "R2");
      drive(1, 8'h81, 1, 0, 0, "R3");
      drive(1, 8'h3E, 1, 0, 1, "R7");
      drive(1, 8'hF6, 1, 0, 0, "R3");
      // Mixed stream against the bit-serial model
      for (int n = 0; n < 300; n++) begin
         logic [7:0] r;
         r = 8'($urandom);
         drive(1'($urandom_range(0, 3) != 0), r, 1'($urandom_range(0, 3) != 0),
               1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 30) == 0), "R3");
      end
      // R1: mid-run reset returns to seed
      drive(1, 8'hC3, 1, 0, 0, "R3");
      @(negedge clk);
      byte_vld = 1'b0; crc_clr = 1'b0;
      rst_n = 1'b0;
      #1;
      compared++;
      if (crc_value !== 16'hFFFF) begin
         mismatched++;
         $display("FAIL R1: crc_value=%h expected=ffff", crc_value);
      end
      @(negedge clk);
      rst_n = 1'b1;
      model = 16'hFFFF;
      exp_q.delete(); tag_q.delete();
      drive(0, 8'h00, 0, 0, 0, "R1");
      drive(1, 8'hF6, 1, 0, 0, "R6", 1, 16'hFF36);
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule